// File: doc/BRIEF.md
# Home Lock Reservation Table

The block sits beside a memory controller and keeps the state of every lock address that currently maps to it. Per-core lock controllers send it three kinds of message: a request to take a lock, a release, and a notice that a lock grant has moved to a new holder. For each accepted message the table answers with at most one message in the next cycle. That answer is one of five kinds: a grant, a retry, an acknowledge, a request forwarded to the controller at the tail of the waiting queue, or a release forwarded to the controller at the head.

Storage is set-associative. The set index comes from the lock-address bits just above the word offset, and the remaining upper bits form the tag. Each entry holds:
- the queue head and tail, each a tuple of thread id, controller id and access mode;
- a count of readers admitted outside the queue;
- a reservation holder with a timestamp.

Nonblocking requesters are never queued. They get a counted read grant when possible. Otherwise they get a retry, and the first such requester reserves the lock so that it cannot be starved.

Top module: `lock_home_table`

## Requirements
- R1: After reset no entry exists and `out_valid_o` is low. An answer appears only in the cycle after an accepted message (`in_valid_i` high).
- R2: A request (`in_op_i`=0) for an address with no entry allocates one, with head and tail both set to the requester. The answer is a grant (`out_op_o`=0) with `out_head_flag_o`=1, addressed to the requester. An address never owns more than one entry.
- R3: A blocking request for a held lock is forwarded (`out_op_o`=3) to the recorded tail. The forward carries the requester in the peer fields and the head tuple in the head fields. The requester then becomes the tail.
- R4: A release (`in_op_i`=1) from the head, when the head equals the tail and the reader count is zero, removes the entry. The answer is an acknowledge (`out_op_o`=2) to the sender.
- R5: A release from the head while a different tail is recorded gets a retry (`out_op_o`=1), and the entry is kept.
- R6: A transfer notice (`in_op_i`=2) replaces the head with the sender and sends an acknowledge to the previous head.
- R7: A nonblocking read request (`in_nonblock_i`=1, `in_write_i`=0) on a lock whose head and tail are both readers gets a grant with `out_head_flag_o`=0. It increments the reader count and leaves the queue pointers unchanged.
- R8: Any other nonblocking request on a held lock gets a retry. If no reservation is live, the requester becomes the reservation holder. While a reservation is live, every request from another thread/controller pair gets a retry.
- R9: A reservation ends when its holder is granted, or once `RESV_TIMEOUT` cycles have passed since it was set.
- R10: A release from a sender that is not the head is handled in one of two ways. A read release while the reader count is nonzero decrements the count and is acknowledged. Any other such release is forwarded (`out_op_o`=4) to the head, with the sender in the peer fields.
- R11: A release from the head while the reader count is nonzero gets a retry, and the entry is kept.
- R12: A request for a new address whose set has no free way gets a retry. No live entry is evicted.
- R13: When a lock is freed while a reservation is live, the address stays reserved. Only the holder's request is then granted with the head flag.
- R14: A release or transfer notice for an address with no held entry produces no answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Incoming message valid |
| in_op_i | input | 2 | 0 request, 1 release, 2 transfer notice |
| in_addr_i | input | ADDR_W | Lock address |
| in_thread_i | input | THR_W | Sender thread id |
| in_ctrl_i | input | CTL_W | Sender controller id |
| in_write_i | input | 1 | 1 write mode, 0 read mode |
| in_nonblock_i | input | 1 | Request comes from a nonblocking entry |
| out_valid_o | output | 1 | Answer valid |
| out_op_o | output | 3 | 0 grant, 1 retry, 2 ack, 3 forwarded request, 4 forwarded release |
| out_addr_o | output | ADDR_W | Lock address of the answer |
| out_dst_thread_o | output | THR_W | Addressed thread |
| out_dst_ctrl_o | output | CTL_W | Addressed controller |
| out_head_flag_o | output | 1 | Grant carries the head token |
| out_peer_thread_o | output | THR_W | Requester or releaser thread carried along |
| out_peer_ctrl_o | output | CTL_W | Requester or releaser controller carried along |
| out_peer_write_o | output | 1 | Requester or releaser mode |
| out_hd_thread_o | output | THR_W | Head thread at the time of the message |
| out_hd_ctrl_o | output | CTL_W | Head controller at the time of the message |
| out_hd_write_o | output | 1 | Head mode |

## Verification
The table is driven through several message sequences:
- A single write owner that grows into a queue, is handed over and is freed. This separates queue forwarding from allocation and removal.
- Read holders joined by nonblocking readers. This shows that the counted path leaves the tail untouched and that the count blocks removal.
- A write-held lock contested by nonblocking requesters. This shows that the reservation survives the lock being freed and that it expires.
- Sixteen addresses packed into one set. This separates set-full retry from eviction.

Releases arriving from a migrated controller, and messages for unknown addresses, show that forwarding and silence come from the head comparison and from the lookup, not from the message kind.

// File: rtl/lock_home_pkg.sv
package lock_home_pkg;
  typedef enum logic [1:0] {
    IN_REQ  = 2'd0,
    IN_REL  = 2'd1,
    IN_XFER = 2'd2
  } in_op_e;

  typedef enum logic [2:0] {
    OUT_GRANT   = 3'd0,
    OUT_RETRY   = 3'd1,
    OUT_ACK     = 3'd2,
    OUT_FWD_REQ = 3'd3,
    OUT_FWD_REL = 3'd4
  } out_op_e;
endpackage

// File: rtl/lock_home_stamp.sv
module lock_home_stamp #(
  parameter int STAMP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [STAMP_W-1:0] now_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_o <= '0;
    else         now_o <= now_o + 1'b1;
  end
endmodule

// File: rtl/lock_home_lookup.sv
module lock_home_lookup #(
  parameter int WAYS         = 16,
  parameter int TAG_W        = 25,
  parameter int STAMP_W      = 16,
  parameter int RESV_TIMEOUT = 256,
  localparam int WAY_W       = $clog2(WAYS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [WAYS-1:0]                 vld_i,
  input  logic [WAYS-1:0]                 held_i,
  input  logic [WAYS-1:0]                 rsv_i,
  input  logic [WAYS-1:0][TAG_W-1:0]      tag_i,
  input  logic [WAYS-1:0][STAMP_W-1:0]    stamp_i,
  input  logic [STAMP_W-1:0]              now_i,
  input  logic [TAG_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [WAY_W-1:0]                hit_way_o,
  output logic                            free_o,
  output logic [WAY_W-1:0]                free_way_o,
  output logic [WAYS-1:0]                 live_o
);
  logic [WAYS-1:0] busy, hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [STAMP_W-1:0] age;
    assign age        = now_i - stamp_i[w];
    assign live_o[w]  = rsv_i[w] && (age < STAMP_W'(RESV_TIMEOUT));
    assign busy[w]    = vld_i[w] && (held_i[w] || live_o[w]);
    assign hit_vec[w] = busy[w] && (tag_i[w] == key_i);
  end

  always_comb begin
    hit_o = 1'b0; hit_way_o = '0; free_o = 1'b0; free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin hit_o = 1'b1; hit_way_o = WAY_W'(w); end
      if (!busy[w])   begin free_o = 1'b1; free_way_o = WAY_W'(w); end
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
endmodule

// File: rtl/lock_home_out_reg.sv
module lock_home_out_reg #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] data_i,
  output logic          valid_o,
  output logic [PW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/lock_home_table.sv
module lock_home_table
  import lock_home_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int THR_W        = 8,
  parameter int CTL_W        = 6,
  parameter int ENTRIES      = 512,
  parameter int WAYS         = 16,
  parameter int WORD_OFF     = 2,
  parameter int CNT_W        = 8,
  parameter int STAMP_W      = 16,
  parameter int RESV_TIMEOUT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        in_op_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [THR_W-1:0]  in_thread_i,
  input  logic [CTL_W-1:0]  in_ctrl_i,
  input  logic              in_write_i,
  input  logic              in_nonblock_i,
  output logic              out_valid_o,
  output logic [2:0]        out_op_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [THR_W-1:0]  out_dst_thread_o,
  output logic [CTL_W-1:0]  out_dst_ctrl_o,
  output logic              out_head_flag_o,
  output logic [THR_W-1:0]  out_peer_thread_o,
  output logic [CTL_W-1:0]  out_peer_ctrl_o,
  output logic              out_peer_write_o,
  output logic [THR_W-1:0]  out_hd_thread_o,
  output logic [CTL_W-1:0]  out_hd_ctrl_o,
  output logic              out_hd_write_o
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - WORD_OFF - SET_W;
  localparam int PW    = 3 + ADDR_W + 3 * (THR_W + CTL_W) + 3;

  // entry storage
  logic               vld_q  [SETS][WAYS];
  logic               rsv_q  [SETS][WAYS];
  logic               held_q [SETS][WAYS];
  logic [TAG_W-1:0]   tag_q  [SETS][WAYS];
  logic [THR_W-1:0]   hthr_q [SETS][WAYS], tthr_q [SETS][WAYS], rthr_q [SETS][WAYS];
  logic [CTL_W-1:0]   hctl_q [SETS][WAYS], tctl_q [SETS][WAYS], rctl_q [SETS][WAYS];
  logic               hwr_q  [SETS][WAYS], twr_q  [SETS][WAYS];
  logic [CNT_W-1:0]   cnt_q  [SETS][WAYS];
  logic [STAMP_W-1:0] rst_q  [SETS][WAYS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] key;
  assign set_idx = in_addr_i[WORD_OFF +: SET_W];
  assign key     = in_addr_i[ADDR_W-1 -: TAG_W];

  logic [STAMP_W-1:0] now;
  lock_home_stamp #(.STAMP_W(STAMP_W)) u_stamp (.clk_i, .rst_ni, .now_o(now));

  logic [WAYS-1:0]              row_vld, row_held, row_rsv, live;
  logic [WAYS-1:0][TAG_W-1:0]   row_tag;
  logic [WAYS-1:0][STAMP_W-1:0] row_stamp;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_vld[w]   = vld_q[set_idx][w];
      row_held[w]  = held_q[set_idx][w];
      row_rsv[w]   = rsv_q[set_idx][w];
      row_tag[w]   = tag_q[set_idx][w];
      row_stamp[w] = rst_q[set_idx][w];
    end
  end

  logic hit, free;
  logic [WAY_W-1:0] hit_way, free_way, tw;
  lock_home_lookup #(
    .WAYS(WAYS), .TAG_W(TAG_W), .STAMP_W(STAMP_W), .RESV_TIMEOUT(RESV_TIMEOUT)
  ) u_lookup (
    .clk_i, .rst_ni,
    .vld_i(row_vld), .held_i(row_held), .rsv_i(row_rsv), .tag_i(row_tag),
    .stamp_i(row_stamp), .now_i(now), .key_i(key),
    .hit_o(hit), .hit_way_o(hit_way), .free_o(free), .free_way_o(free_way),
    .live_o(live)
  );
  assign tw = hit ? hit_way : free_way;

  // next entry image and answer
  logic wr_en, e_vld, e_held, e_rsv, e_hwr, e_twr;
  logic [THR_W-1:0] e_hthr, e_tthr, e_rthr;
  logic [CTL_W-1:0] e_hctl, e_tctl, e_rctl;
  logic [CNT_W-1:0] e_cnt;
  logic [STAMP_W-1:0] e_rst;
  logic is_head, is_holder, single;
  logic o_v, o_hf;
  logic [2:0] o_op;
  logic [THR_W-1:0] o_thr;
  logic [CTL_W-1:0] o_ctl;

  always_comb begin
    e_vld  = vld_q[set_idx][tw];  e_held = held_q[set_idx][tw];
    e_hthr = hthr_q[set_idx][tw]; e_hctl = hctl_q[set_idx][tw]; e_hwr = hwr_q[set_idx][tw];
    e_tthr = tthr_q[set_idx][tw]; e_tctl = tctl_q[set_idx][tw]; e_twr = twr_q[set_idx][tw];
    e_cnt  = cnt_q[set_idx][tw];
    e_rsv  = rsv_q[set_idx][tw] && live[tw];
    e_rthr = rthr_q[set_idx][tw]; e_rctl = rctl_q[set_idx][tw]; e_rst = rst_q[set_idx][tw];
    is_head   = (e_hthr == in_thread_i) && (e_hctl == in_ctrl_i);
    is_holder = e_rsv && (e_rthr == in_thread_i) && (e_rctl == in_ctrl_i);
    single    = (e_hthr == e_tthr) && (e_hctl == e_tctl);
    o_hd_thr  = e_hthr; o_hd_ctl = e_hctl; o_hd_wr = e_hwr;
    wr_en = 1'b0; o_v = 1'b0; o_op = OUT_RETRY; o_hf = 1'b0;
    o_thr = in_thread_i; o_ctl = in_ctrl_i;
    if (in_valid_i) begin
      unique case (in_op_i)
        IN_REQ: begin
          o_v = 1'b1;
          if (!hit || (!e_held && is_holder)) begin
            if (hit || free) begin
              wr_en = 1'b1; e_vld = 1'b1; e_held = 1'b1; e_cnt = '0; e_rsv = 1'b0;
              e_hthr = in_thread_i; e_hctl = in_ctrl_i; e_hwr = in_write_i;
              e_tthr = in_thread_i; e_tctl = in_ctrl_i; e_twr = in_write_i;
              o_op = OUT_GRANT; o_hf = 1'b1;
            end
          end else if (!e_held || (e_rsv && !is_holder)) begin
            o_op = OUT_RETRY;
          end else if (in_nonblock_i) begin
            if (!e_hwr && !e_twr && !in_write_i && (e_cnt != '1)) begin
              wr_en = 1'b1; e_cnt = e_cnt + 1'b1; e_rsv = 1'b0; o_op = OUT_GRANT;
            end else if (!e_rsv) begin
              wr_en = 1'b1; e_rsv = 1'b1; e_rthr = in_thread_i; e_rctl = in_ctrl_i; e_rst = now;
            end
          end else begin
            o_op = OUT_FWD_REQ; o_thr = e_tthr; o_ctl = e_tctl;
            wr_en = 1'b1; e_tthr = in_thread_i; e_tctl = in_ctrl_i; e_twr = in_write_i;
          end
        end
        IN_REL: if (hit && e_held) begin
          o_v = 1'b1;
          if (is_head) begin
            if (single && (e_cnt == '0)) begin
              wr_en = 1'b1; o_op = OUT_ACK;
              if (e_rsv) e_held = 1'b0;
              else       e_vld  = 1'b0;
            end
          end else if (!in_write_i && (e_cnt != '0)) begin
            wr_en = 1'b1; e_cnt = e_cnt - 1'b1; o_op = OUT_ACK;
          end else begin
            o_op = OUT_FWD_REL; o_thr = e_hthr; o_ctl = e_hctl;
          end
        end
        IN_XFER: if (hit && e_held) begin
          o_v = 1'b1; o_op = OUT_ACK; o_thr = e_hthr; o_ctl = e_hctl;
          wr_en = 1'b1; e_hthr = in_thread_i; e_hctl = in_ctrl_i; e_hwr = in_write_i;
        end
        default: ;
      endcase
    end
  end

  logic [THR_W-1:0] o_hd_thr;
  logic [CTL_W-1:0] o_hd_ctl;
  logic             o_hd_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          rsv_q[s][w] <= 1'b0;
        end
    end else if (wr_en) begin
      vld_q[set_idx][tw] <= e_vld;
      rsv_q[set_idx][tw] <= e_rsv;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      held_q[set_idx][tw] <= e_held; tag_q[set_idx][tw] <= key;
      hthr_q[set_idx][tw] <= e_hthr; hctl_q[set_idx][tw] <= e_hctl; hwr_q[set_idx][tw] <= e_hwr;
      tthr_q[set_idx][tw] <= e_tthr; tctl_q[set_idx][tw] <= e_tctl; twr_q[set_idx][tw] <= e_twr;
      cnt_q[set_idx][tw]  <= e_cnt;
      rthr_q[set_idx][tw] <= e_rthr; rctl_q[set_idx][tw] <= e_rctl; rst_q[set_idx][tw] <= e_rst;
    end
  end

  logic [PW-1:0] pay_d, pay_q;
  assign pay_d = {o_op, in_addr_i, o_thr, o_ctl, o_hf,
                  in_thread_i, in_ctrl_i, in_write_i, o_hd_thr, o_hd_ctl, o_hd_wr};

  lock_home_out_reg #(.PW(PW)) u_out (
    .clk_i, .rst_ni, .valid_i(o_v), .data_i(pay_d), .valid_o(out_valid_o), .data_o(pay_q)
  );
  assign {out_op_o, out_addr_o, out_dst_thread_o, out_dst_ctrl_o, out_head_flag_o,
          out_peer_thread_o, out_peer_ctrl_o, out_peer_write_o,
          out_hd_thread_o, out_hd_ctrl_o, out_hd_write_o} = pay_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R1
  AST_ALLOC_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_op_i == IN_REQ && !hit && free)
      |=> (out_valid_o && out_op_o == OUT_GRANT && out_head_flag_o)); // R2
  AST_REQ_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_op_i == IN_REQ) |=> (out_op_o != OUT_ACK)); // R4
  AST_FWD_REL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_op_o == OUT_FWD_REL) |-> $past(in_valid_i && in_op_i == IN_REL)); // R10
  AST_FULL_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_op_i == IN_REQ && !hit && !free)
      |=> (out_valid_o && out_op_o == OUT_RETRY)); // R12
  AST_NO_ENTRY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_op_i != IN_REQ && !hit) |=> !out_valid_o); // R14
endmodule

// File: tb/lock_home_table_tb.sv
module lock_home_table_tb;
  import lock_home_pkg::*;
  localparam int AW = 32, TW = 8, CW = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0, in_write = 1'b0, in_nb = 1'b0;
  logic [1:0]    in_op = '0;
  logic [AW-1:0] in_addr = '0;
  logic [TW-1:0] in_thr = '0;
  logic [CW-1:0] in_ctl = '0;
  logic          out_valid, out_hf, out_pwr, out_hwr;
  logic [2:0]    out_op;
  logic [AW-1:0] out_addr;
  logic [TW-1:0] out_dthr, out_pthr, out_hthr;
  logic [CW-1:0] out_dctl, out_pctl, out_hctl;
  int n_chk = 0, n_err = 0;

  lock_home_table #(.RESV_TIMEOUT(20)) u_dut (
    .clk_i(clk), .rst_ni, .in_valid_i(in_valid), .in_op_i(in_op), .in_addr_i(in_addr),
    .in_thread_i(in_thr), .in_ctrl_i(in_ctl), .in_write_i(in_write), .in_nonblock_i(in_nb),
    .out_valid_o(out_valid), .out_op_o(out_op), .out_addr_o(out_addr),
    .out_dst_thread_o(out_dthr), .out_dst_ctrl_o(out_dctl), .out_head_flag_o(out_hf),
    .out_peer_thread_o(out_pthr), .out_peer_ctrl_o(out_pctl), .out_peer_write_o(out_pwr),
    .out_hd_thread_o(out_hthr), .out_hd_ctrl_o(out_hctl), .out_hd_write_o(out_hwr)
  );

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input int thr, input int ctl,
                      input logic wr, input logic nb);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_addr = a; in_thr = TW'(thr); in_ctl = CW'(ctl);
    in_write = wr; in_nb = nb;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_msg(input string rq, input logic [2:0] op, input int thr, input int ctl,
                            input logic hf);
    n_chk++;
    if (!out_valid || out_op != op || out_dthr != TW'(thr) || out_dctl != CW'(ctl) || out_hf != hf) begin
      n_err++;
      $display("FAIL %s: got v=%0b op=%0d thr=%0d ctl=%0d hf=%0b, exp v=1 op=%0d thr=%0d ctl=%0d hf=%0b",
               rq, out_valid, out_op, out_dthr, out_dctl, out_hf, op, thr, ctl, hf);
    end
  endtask

  task automatic expect_tuple(input string rq, input int pthr, input int pctl, input int hthr,
                              input int hctl);
    n_chk++;
    if (out_pthr != TW'(pthr) || out_pctl != CW'(pctl) || out_hthr != TW'(hthr) || out_hctl != CW'(hctl)) begin
      n_err++;
      $display("FAIL %s: got peer=%0d/%0d head=%0d/%0d, exp peer=%0d/%0d head=%0d/%0d",
               rq, out_pthr, out_pctl, out_hthr, out_hctl, pthr, pctl, hthr, hctl);
    end
  endtask

  task automatic expect_none(input string rq);
    n_chk++;
    if (out_valid) begin
      n_err++;
      $display("FAIL %s: got out_valid=1 op=%0d, exp out_valid=0", rq, out_op);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    expect_none("R1 quiet in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    expect_none("R1 quiet after reset");
  endtask

  task automatic t_queue;
    logic [AW-1:0] a = 32'h100;
    send(IN_REQ, a, 1, 1, 1, 0);  expect_msg("R2 alloc grant", OUT_GRANT, 1, 1, 1);
    send(IN_REQ, a, 2, 2, 1, 0);  expect_msg("R3 forward to tail", OUT_FWD_REQ, 1, 1, 0);
    expect_tuple("R3 forward tuples", 2, 2, 1, 1);
    send(IN_REQ, a, 3, 3, 1, 0);  expect_msg("R3 tail moved", OUT_FWD_REQ, 2, 2, 0);
    send(IN_REL, a, 1, 1, 1, 0);  expect_msg("R5 head release with queue", OUT_RETRY, 1, 1, 0);
    send(IN_XFER, a, 2, 2, 1, 0); expect_msg("R6 ack previous head", OUT_ACK, 1, 1, 0);
    send(IN_REL, a, 1, 1, 1, 0);  expect_msg("R10 stale release forwarded", OUT_FWD_REL, 2, 2, 0);
    expect_tuple("R10 forwarded sender", 1, 1, 2, 2);
    send(IN_XFER, a, 3, 3, 1, 0); expect_msg("R6 second handover", OUT_ACK, 2, 2, 0);
    send(IN_REL, a, 3, 3, 1, 0);  expect_msg("R4 last release ack", OUT_ACK, 3, 3, 0);
    send(IN_REQ, a, 4, 4, 1, 0);  expect_msg("R4 entry removed", OUT_GRANT, 4, 4, 1);
    send(IN_REL, a, 4, 4, 1, 0);  expect_msg("R4 cleanup", OUT_ACK, 4, 4, 0);
  endtask

  task automatic t_migrate;
    logic [AW-1:0] a = 32'h200;
    send(IN_REQ, a, 5, 5, 1, 0); expect_msg("R2 owner grant", OUT_GRANT, 5, 5, 1);
    send(IN_REL, a, 5, 9, 1, 0); expect_msg("R10 migrated release", OUT_FWD_REL, 5, 5, 0);
    expect_tuple("R10 migrated sender", 5, 9, 5, 5);
    send(IN_REL, a, 5, 5, 1, 0); expect_msg("R4 home release", OUT_ACK, 5, 5, 0);
  endtask

  task automatic t_readers;
    logic [AW-1:0] a = 32'h300, b = 32'h400;
    send(IN_REQ, a, 1, 1, 0, 0); expect_msg("R2 reader grant", OUT_GRANT, 1, 1, 1);
    send(IN_REQ, a, 7, 7, 0, 1); expect_msg("R7 counted read", OUT_GRANT, 7, 7, 0);
    send(IN_REL, a, 1, 1, 0, 0); expect_msg("R11 head release with readers", OUT_RETRY, 1, 1, 0);
    send(IN_REL, a, 7, 7, 0, 0); expect_msg("R10 counted reader leaves", OUT_ACK, 7, 7, 0);
    send(IN_REL, a, 1, 1, 0, 0); expect_msg("R4 release after drain", OUT_ACK, 1, 1, 0);
    send(IN_REQ, b, 1, 1, 0, 0); expect_msg("R2 reader grant b", OUT_GRANT, 1, 1, 1);
    send(IN_REQ, b, 8, 8, 0, 1); expect_msg("R7 counted read b", OUT_GRANT, 8, 8, 0);
    send(IN_REQ, b, 9, 9, 1, 0); expect_msg("R7 tail untouched", OUT_FWD_REQ, 1, 1, 0);
  endtask

  task automatic t_reserve;
    logic [AW-1:0] a = 32'h500, b = 32'h600;
    send(IN_REQ, a, 1, 1, 1, 0); expect_msg("R2 writer grant", OUT_GRANT, 1, 1, 1);
    send(IN_REQ, a, 2, 2, 0, 1); expect_msg("R8 nonblocking retry", OUT_RETRY, 2, 2, 0);
    send(IN_REQ, a, 3, 3, 0, 1); expect_msg("R8 other nonblocking", OUT_RETRY, 3, 3, 0);
    send(IN_REQ, a, 4, 4, 1, 0); expect_msg("R8 blocking refused", OUT_RETRY, 4, 4, 0);
    send(IN_REL, a, 1, 1, 1, 0); expect_msg("R13 release while reserved", OUT_ACK, 1, 1, 0);
    send(IN_REQ, a, 3, 3, 0, 0); expect_msg("R13 non-holder refused", OUT_RETRY, 3, 3, 0);
    send(IN_REQ, a, 2, 2, 0, 1); expect_msg("R13 holder takes lock", OUT_GRANT, 2, 2, 1);
    send(IN_REQ, a, 3, 3, 0, 1); expect_msg("R9 cleared on grant", OUT_GRANT, 3, 3, 0);
    send(IN_REQ, b, 1, 1, 1, 0); expect_msg("R2 writer grant b", OUT_GRANT, 1, 1, 1);
    send(IN_REQ, b, 2, 2, 1, 1); expect_msg("R8 reserve b", OUT_RETRY, 2, 2, 0);
    repeat (30) @(negedge clk);
    send(IN_REQ, b, 4, 4, 1, 0); expect_msg("R9 timeout expired", OUT_FWD_REQ, 1, 1, 0);
  endtask

  task automatic t_full;
    for (int k = 0; k < 16; k++) begin
      send(IN_REQ, 32'h1_0000 + 32'(k * 128) + 32'd12, 10 + k, k, 1, 0);
      expect_msg("R12 fill set", OUT_GRANT, 10 + k, k, 1);
    end
    send(IN_REQ, 32'h1_0000 + 32'(16 * 128) + 32'd12, 60, 30, 1, 0);
    expect_msg("R12 full set retry", OUT_RETRY, 60, 30, 0);
    send(IN_REQ, 32'h1_000c, 40, 40, 1, 0);
    expect_msg("R12 no eviction", OUT_FWD_REQ, 10, 0, 0);
    send(IN_REL, 32'h1_0000 + 32'(5 * 128) + 32'd12, 15, 5, 1, 0);
    expect_msg("R4 free one way", OUT_ACK, 15, 5, 0);
    send(IN_REQ, 32'h1_0000 + 32'(16 * 128) + 32'd12, 60, 30, 1, 0);
    expect_msg("R12 way reused", OUT_GRANT, 60, 30, 1);
  endtask

  task automatic t_unknown;
    send(IN_REL, 32'h9000, 1, 1, 1, 0);  expect_none("R14 release unknown");
    send(IN_XFER, 32'h9000, 1, 1, 1, 0); expect_none("R14 transfer unknown");
    @(negedge clk);                       expect_none("R1 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got no finish, exp finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_queue();
    t_migrate();
    t_readers();
    t_reserve();
    t_full();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule